// File: doc/BRIEF.md
# Plateau-Start Frame Detector

This block watches the power stream produced by a long-window autocorrelator in an OFDM receiver and marks the sample at which a frame is considered found. The correlator power rises to a flat plateau when a periodic preamble arrives. A lagged differentiator turns the leading edge of that plateau into a single absolute maximum. Two peak detectors then examine the differentiated stream side by side. The first holds a running maximum and counts how long that maximum has stood. The second sums the stream in blocks of six samples and watches for a block that is smaller than the block before it. A detection is declared only on a sample where both report at once.

When it fires, the block gives a one-cycle pulse and the index of the triggering sample, counted from the last rearm. It then ignores its input until the receiver control asserts the rearm input. A power threshold stage upstream flags each sample, and the block uses only flagged power. With a clean step, detection lands sixteen samples after the plateau begins.

Top module: `plateau_start_detector`

## Requirements
- R1: After reset, `det_pulse` is low, `det_index` is 0, and the block is armed, so it accepts samples.
- R2: A sample whose `in_pass` flag is low is treated as power 0 in every later stage.
- R3: The differentiated value for sample k is d(k) = P(k) − P(k−16) when that is positive, and 0 otherwise. The lag history reads as zero for the first 16 samples after reset or rearm.
- R4: The running-maximum detector replaces its stored maximum with d(k) when d(k) is strictly greater, and clears its 4-bit counter. Otherwise the counter increments and saturates at 15. A relative peak is reported on a sample where d(k) does not exceed the maximum and the counter already reads 15.
- R5: Groups of 6 consecutive accepted samples are aligned to the first sample after reset or rearm. On the last sample of each group, a falling edge is reported if that group's sum is strictly less than the previous group's sum. The first group never reports one.
- R6: When the relative peak and the falling edge are both reported on the same accepted sample, `det_pulse` is high for exactly the following cycle. `det_index` then shows that sample's 0-based index among the samples accepted since reset or rearm.
- R7: Take 19 zero samples followed by a constant level. Detection then falls on sample index 35, which is 16 samples after the step.
- R8: After a detection, samples are ignored and no further pulse occurs until `rearm` is asserted. `det_index` keeps its value during this time.
- R9: `rearm` clears the stored maximum, counter, group sums, lag history, sample index and `det_index`, and re-arms the block. A sample presented in the same cycle as `rearm` is discarded.
- R10: Cycles with `in_valid` low do not advance the sample index or any detector state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A power sample is presented this cycle |
| in_power | input | 16 | Squared-magnitude sample from the long autocorrelator |
| in_pass | input | 1 | Sample is above the power threshold |
| rearm | input | 1 | Clear the detector state and accept samples again |
| det_pulse | output | 1 | One-cycle frame-detect pulse |
| det_index | output | 12 | Index of the sample that triggered detection |

## Verification
The bench aims at the exact landing point of a clean step. A relative-peak counter that is off by one would move the detection away from index 35, or would miss the group boundary and shift it by a whole group. Threshold-rejected plateaus and a second plateau after a detection must produce no pulse. A design that leaks masked power or forgets to disarm would raise a pulse that the scoreboard does not expect. A rearm given together with a sample, bursts with idle gaps, and a pseudo-random stream all check that index counting and group alignment restart and pause correctly. A design that counts a discarded or idle cycle would report every later index off by one.

// File: rtl/psd_pkg.sv
// Shared constants and helpers for the plateau-start detector.
// Assumes unsigned power samples; all arithmetic is unsigned.
package psd_pkg;
    localparam int unsigned PSD_DW    = 16;  // power sample width
    localparam int unsigned PSD_LAG   = 16;  // differentiator lag in samples
    localparam int unsigned PSD_GROUP = 6;   // samples per group sum
    localparam int unsigned PSD_CNT_W = 4;   // running-max timeout counter width
    localparam int unsigned PSD_IDX_W = 12;  // sample index width

    // Arm state of the detector.
    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_t;
endpackage

// File: rtl/psd_lag_diff.sv
// Lagged differentiator: d = max(p_in - p_in delayed by LAG samples, 0).
// Assumes shift is high only for accepted samples; clr empties the history.
module psd_lag_diff #(
    parameter int unsigned DW  = 16,
    parameter int unsigned LAG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift,
    input  logic [DW-1:0] p_in,
    output logic [DW-1:0] d_out
);
    logic [DW-1:0] tap [LAG];

    for (genvar gi = 0; gi < LAG; gi++) begin : g_tap
        if (gi == 0) begin : g_head
            // Purpose: load the newest sample into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  tap[gi] <= '0;
                else if (shift)     tap[gi] <= p_in;
            end
        end else begin : g_body
            // Purpose: move history one stage along on each accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  tap[gi] <= '0;
                else if (shift)     tap[gi] <= tap[gi-1];
            end
        end
    end

    // Purpose: positive part of the difference against the oldest stage.
    always_comb begin
        if (p_in > tap[LAG-1]) d_out = p_in - tap[LAG-1];
        else                   d_out = '0;
    end
endmodule

// File: rtl/psd_run_max.sv
// Running-maximum detector with a saturating timeout counter.
// Reports a relative peak when the maximum has stood for the full counter range.
// Assumes step is high only for accepted samples.
module psd_run_max #(
    parameter int unsigned DW    = 16,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DW-1:0]    d_in,
    output logic             rel_peak,
    output logic [DW-1:0]    max_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic exceeds;
    assign exceeds = d_in > max_q;

    // Purpose: update the stored maximum and the timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            max_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            if (exceeds) begin
                max_q <= d_in;
                cnt_q <= '0;
            end else if (cnt_q != CNT_TOP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Purpose: relative peak once the counter has run through its range.
    assign rel_peak = step && !exceeds && (cnt_q == CNT_TOP);
endmodule

// File: rtl/psd_group_fall.sv
// Group falling-edge detector: sums non-overlapping groups of GROUP samples
// and flags a group whose sum is below the previous group's sum.
// Assumes step is high only for accepted samples; groups align to clr.
module psd_group_fall #(
    parameter int unsigned DW    = 16,
    parameter int unsigned GROUP = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        step,
    input  logic [DW-1:0]               d_in,
    output logic                        fall,
    output logic [$clog2(GROUP)-1:0]    phase_q
);
    localparam int unsigned PH_W = $clog2(GROUP);
    localparam int unsigned SW   = DW + PH_W;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP - 1);

    logic [SW-1:0] acc_q;
    logic [SW-1:0] prev_q;
    logic          have_prev_q;
    logic [SW-1:0] sum_now;
    logic          last_in_group;

    assign sum_now       = acc_q + SW'(d_in);
    assign last_in_group = (phase_q == PH_LAST);

    // Purpose: accumulate the current group and retire it at its last sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q       <= '0;
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            phase_q     <= '0;
        end else if (step) begin
            if (last_in_group) begin
                prev_q      <= sum_now;
                have_prev_q <= 1'b1;
                acc_q       <= '0;
                phase_q     <= '0;
            end else begin
                acc_q   <= sum_now;
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // Purpose: falling slope when a completed group is below its predecessor.
    assign fall = step && last_in_group && have_prev_q && (sum_now < prev_q);
endmodule

// File: rtl/plateau_start_detector.sv
// Plateau-start frame detector. Masks sub-threshold power, differentiates it
// over a lag, and declares a frame when the running-maximum detector and the
// group falling-edge detector agree on the same sample. Disarms after a
// detection until rearm. Assumes at most one sample per cycle.
module plateau_start_detector
    import psd_pkg::*;
#(
    parameter int unsigned DW    = PSD_DW,
    parameter int unsigned LAG   = PSD_LAG,
    parameter int unsigned GROUP = PSD_GROUP,
    parameter int unsigned CNT_W = PSD_CNT_W,
    parameter int unsigned IDX_W = PSD_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_power,
    input  logic             in_pass,
    input  logic             rearm,
    output logic             det_pulse,
    output logic [IDX_W-1:0] det_index
);
    localparam int unsigned PH_W = $clog2(GROUP);

    arm_state_t       arm_q;
    logic             armed;
    logic             accept;
    logic [DW-1:0]    p_eff;
    logic [DW-1:0]    d_val;
    logic             rel_peak;
    logic [DW-1:0]    max_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fall;
    logic [PH_W-1:0]  phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit;

    assign armed  = (arm_q == ST_ARMED);
    assign accept = in_valid && armed && !rearm;
    assign p_eff  = in_pass ? in_power : '0;
    assign hit    = accept && rel_peak && fall;

    psd_lag_diff #(.DW(DW), .LAG(LAG)) i_diff (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rearm),
        .shift (accept),
        .p_in  (p_eff),
        .d_out (d_val)
    );

    psd_run_max #(.DW(DW), .CNT_W(CNT_W)) i_runmax (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rearm),
        .step     (accept),
        .d_in     (d_val),
        .rel_peak (rel_peak),
        .max_q    (max_q),
        .cnt_q    (cnt_q)
    );

    psd_group_fall #(.DW(DW), .GROUP(GROUP)) i_group (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rearm),
        .step    (accept),
        .d_in    (d_val),
        .fall    (fall),
        .phase_q (phase_q)
    );

    // Purpose: arm after reset or rearm, disarm on a detection.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm) arm_q <= ST_ARMED;
        else if (hit)        arm_q <= ST_DISARMED;
    end

    // Purpose: count accepted samples since reset or rearm.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm) idx_q <= '0;
        else if (accept)     idx_q <= idx_q + 1'b1;
    end

    // Purpose: register the detect pulse and latch the triggering index.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm) begin
            det_pulse <= 1'b0;
            det_index <= '0;
        end else begin
            det_pulse <= hit;
            if (hit) det_index <= idx_q;
        end
    end
endmodule

// File: rtl/psd_checker.sv
// Temporal checks for the plateau-start detector, bound to the top module.
module psd_checker #(
    parameter int unsigned DW    = 16,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned PH_W  = 3,
    parameter int unsigned GROUP = 6,
    parameter int unsigned IDX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rearm,
    input logic             accept,
    input logic             armed,
    input logic [DW-1:0]    d_val,
    input logic [DW-1:0]    max_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             rel_peak,
    input logic             fall,
    input logic [PH_W-1:0]  phase_q,
    input logic [IDX_W-1:0] idx_q,
    input logic             det_pulse,
    input logic [IDX_W-1:0] det_index
);
    assert_new_max_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (d_val > max_q)) |=> (cnt_q == '0));

    assert_fall_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (phase_q == PH_W'(GROUP - 1)));

    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(accept && rel_peak && fall));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |=> !det_pulse);

    assert_silent_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !rearm) |=> (!det_pulse && $stable(det_index)));

    assert_rearm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (det_index == '0 && idx_q == '0 && max_q == '0 && armed));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !rearm) |=> ($stable(idx_q) && $stable(cnt_q) && $stable(phase_q)));
endmodule

bind plateau_start_detector psd_checker #(
    .DW(DW), .CNT_W(CNT_W), .PH_W($clog2(GROUP)), .GROUP(GROUP), .IDX_W(IDX_W)
) i_psd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rearm     (rearm),
    .accept    (accept),
    .armed     (armed),
    .d_val     (d_val),
    .max_q     (max_q),
    .cnt_q     (cnt_q),
    .rel_peak  (rel_peak),
    .fall      (fall),
    .phase_q   (phase_q),
    .idx_q     (idx_q),
    .det_pulse (det_pulse),
    .det_index (det_index)
);

// File: tb/test_plateau_start_detector.sv
// Scoreboard bench: the driver predicts detections from the requirements and
// queues expected indices; the monitor pops them as pulses appear.
module test_plateau_start_detector;
    localparam int CLK_P = 10;
    localparam int DW    = 16;
    localparam int IDX_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [DW-1:0]    in_power = '0;
    logic             in_pass = 1'b0;
    logic             rearm = 1'b0;
    logic             det_pulse;
    logic [IDX_W-1:0] det_index;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;
    int exp_q[$];

    // requirement model state
    int hist[16];
    int hp, mx, cnt, acc, ph, prv, k;
    bit hv, m_armed;

    always #(CLK_P/2) clk = ~clk;

    plateau_start_detector i_plateau_start_detector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_power(in_power),
        .in_pass(in_pass), .rearm(rearm), .det_pulse(det_pulse), .det_index(det_index)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        foreach (hist[i]) hist[i] = 0;
        hp = 0; mx = 0; cnt = 0; acc = 0; ph = 0; prv = 0; k = 0;
        hv = 0; m_armed = 1;
    endtask

    // One accepted sample per R2..R6.
    task automatic model_step(input int pw, input bit pass);
        int p, d, sum;
        bit rel, fl;
        if (!m_armed) return;                 // R8: ignored while disarmed
        p = pass ? pw : 0;                    // R2
        d = (p > hist[hp]) ? p - hist[hp] : 0; // R3
        hist[hp] = p;
        hp = (hp + 1) % 16;
        rel = (d <= mx) && (cnt == 15);       // R4
        if (d > mx) begin mx = d; cnt = 0; end
        else if (cnt != 15) cnt++;
        sum = acc + d;                        // R5
        fl = (ph == 5) && hv && (sum < prv);
        if (ph == 5) begin prv = sum; hv = 1; acc = 0; ph = 0; end
        else begin acc = sum; ph++; end
        if (rel && fl) begin                  // R6
            exp_q.push_back(k);
            m_armed = 0;
        end
        k++;
    endtask

    task automatic send(input int pw, input bit pass);
        @(negedge clk);
        in_valid = 1'b1; in_power = DW'(pw); in_pass = pass; rearm = 1'b0;
        model_step(pw, pass);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_rearm(input bit with_sample);
        @(negedge clk);
        rearm = 1'b1;
        in_valid = with_sample; in_power = 16'd5000; in_pass = 1'b1;
        model_clear();                        // R9: sample discarded
        @(posedge clk);
        #1 rearm = 1'b0; in_valid = 1'b0;
    endtask

    task automatic step_plateau(input int lvl, input bit pass);
        for (int i = 0; i < 19; i++) send(0, 1'b1);
        for (int i = 0; i < 60; i++) send(lvl, pass);
        for (int i = 0; i < 40; i++) send(0, 1'b1);
        idle(3);
    endtask

    // Monitor: compare each pulse with the head of the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rst_n && det_pulse) begin
                pulses++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R8 unexpected pulse", int'(det_index), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(det_index) == e, "R6 det_index", int'(det_index), e);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        int lcg;
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        check(det_pulse == 1'b0, "R1 pulse low", det_pulse, 0);
        check(det_index == '0, "R1 index zero", det_index, 0);

        // R7: clean step lands on index 35
        step_plateau(1000, 1'b1);
        check(pulses == 1, "R7 one detection", pulses, 1);
        check(det_index == 12'd35, "R7 index 16 after step", det_index, 35);

        // R8: second plateau while disarmed
        step_plateau(2000, 1'b1);
        check(pulses == 1, "R8 ignored while disarmed", pulses, 1);
        check(det_index == 12'd35, "R8 index held", det_index, 35);

        // R9: rearm clears
        do_rearm(1'b0);
        #2;
        check(det_index == '0, "R9 index cleared", det_index, 0);

        // R2: plateau below threshold does not detect
        p0 = pulses;
        step_plateau(1000, 1'b0);
        check(pulses == p0, "R2 masked plateau", pulses - p0, 0);
        check(exp_q.size() == 0, "R2 model agrees", exp_q.size(), 0);
        step_plateau(1500, 1'b1);
        check(pulses == p0 + 1, "R3 detect after masked plateau", pulses - p0, 1);

        // R4/R10: ramp then plateau with idle gaps
        do_rearm(1'b0);
        for (int i = 0; i < 40; i++) send(i * 50, 1'b1);
        for (int i = 0; i < 60; i++) begin send(3000, 1'b1); if (i % 7 == 3) idle(2); end
        for (int i = 0; i < 40; i++) begin send(0, 1'b1); if (i % 5 == 1) idle(3); end
        idle(3);
        check(exp_q.size() == 0, "R10 ramp detections matched", exp_q.size(), 0);

        // R9: rearm with a same-cycle sample, then clean step again gives 35
        do_rearm(1'b1);
        p0 = pulses;
        step_plateau(800, 1'b1);
        check(pulses == p0 + 1, "R9 detect after rearm", pulses - p0, 1);
        check(det_index == 12'd35, "R9 discarded sample not counted", det_index, 35);

        // R5/R6: pseudo-random stream across several rearms
        lcg = 12345;
        for (int r = 0; r < 4; r++) begin
            do_rearm(1'b0);
            for (int i = 0; i < 300; i++) begin
                lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
                send((lcg >> 8) & 16'h0fff, ((lcg >> 4) & 3) != 0);
            end
            idle(3);
        end
        check(exp_q.size() == 0, "R5 all predicted detections seen", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule